// File: doc/BRIEF.md
# DTMF Digit Steering and Guard Timing

This block follows a tone-pair detector. Each clock the detector reports whether a valid tone pair is present and, if so, which 4-bit digit it is. The block decides when that report has lasted long enough to count as a digit. It latches the digit, and it decides when the tone has been gone long enough to accept the next one. A digital counter pair stands in for an analog RC steering network.

An early flag follows the detector's presence flag one cycle later and drops at once on any gap. An acquisition timer counts cycles while the early flag is high and no digit is held. When it expires, the steering flag rises, the digit latch loads and a one-cycle strobe marks the new digit. A release timer counts cycles while the early flag is low and the steering flag is high. When it expires, the steering flag falls and the block can accept a fresh digit. Both guard lengths come in on ports.

Top module: `dtmf_steer`

## Requirements
- R1: After a synchronous reset, `early_o`, `steer_o`, `guard_o` and `new_o` are 0 and `digit_o` is 0.
- R2: `early_o` equals the value `pair_vld` had at the previous clock edge. It rises one cycle after `pair_vld` rises and falls one cycle after `pair_vld` falls.
- R3: If `early_o` rises after edge k and stays high while `steer_o` is low, `steer_o` rises after edge k+L, where L is `acq_len` (a value of 0 acts as 1). In that same cycle `digit_o` takes the code presented with the tone pair.
- R4: If the presence flag lasts fewer than L cycles, `steer_o` stays low and `digit_o` keeps its value.
- R5: If `early_o` falls after edge j while `steer_o` is high, `steer_o` falls after edge j+R, where R is `rel_len` (a value of 0 acts as 1). `digit_o` keeps the latched code.
- R6: A gap in the presence flag shorter than R cycles while steered leaves `steer_o` high and produces no `new_o` pulse.
- R7: `new_o` is high for exactly one cycle, namely the cycle in which `steer_o` rises. `digit_o` changes only in that cycle. Changes to `pair_code` while steered are ignored.
- R8: `guard_o` is high exactly when `early_o` and `steer_o` differ, i.e. while a guard timer is running.
- R9: A new digit is accepted only after `steer_o` has fallen. Each acquisition needs a fresh run of L cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_vld | input | 1 | Detector reports a valid tone pair this cycle |
| pair_code | input | 4 | Digit code from the detector |
| acq_len | input | CNT_W | Tone-present guard length in cycles |
| rel_len | input | CNT_W | Tone-absent guard length in cycles |
| early_o | output | 1 | Early steering flag |
| steer_o | output | 1 | Delayed steering flag (digit held) |
| guard_o | output | 1 | Guard timer running |
| digit_o | output | 4 | Latched digit code |
| new_o | output | 1 | One-cycle new-digit strobe |

## Verification
A counter that fails to clear on a dropout would show up as `steer_o` rising too early after a broken tone. An off-by-one in the expiry compare moves the `steer_o` edge by exactly one cycle relative to `early_o`. A latch enable that is wrong shows as `digit_o` moving without `new_o`, or as a code change picked up while steered. The sweep covers every small guard length for both timers, so each of these faults shows within a few cycles of the edge concerned.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/dtmf_steer_early.sv
module dtmf_steer_early
  import dtmf_steer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pair_vld,
  input  digit_t pair_code,
  output logic   early_q,
  output digit_t code_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= 1'b0;
      code_q  <= '0;
    end else begin
      early_q <= pair_vld;
      code_q  <= pair_code;
    end
  end
endmodule

// File: rtl/dtmf_steer_timer.sv
module dtmf_steer_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   nxt;

  assign nxt    = {1'b0, cnt} + 1'b1;
  assign expire = run && (nxt >= {1'b0, len});

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (!run || expire) cnt <= '0;
    else                     cnt <= nxt[CNT_W-1:0];
  end

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/dtmf_steer_latch.sv
module dtmf_steer_latch
  import dtmf_steer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  digit_t code_in,
  output digit_t digit_q,
  output logic   new_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      digit_q <= '0;
      new_q   <= 1'b0;
    end else begin
      new_q <= load;
      if (load) digit_q <= code_in;
    end
  end
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pair_vld,
  input  logic [3:0]       pair_code,
  input  logic [CNT_W-1:0] acq_len,
  input  logic [CNT_W-1:0] rel_len,
  output logic             early_o,
  output logic             steer_o,
  output logic             guard_o,
  output logic [3:0]       digit_o,
  output logic             new_o
);
  logic   early_q, steer_q, acq_exp, rel_exp;
  digit_t code_q, digit_q;

  dtmf_steer_early u_early (
    .clk(clk), .rst(rst), .pair_vld(pair_vld), .pair_code(pair_code),
    .early_q(early_q), .code_q(code_q)
  );

  dtmf_steer_timer #(.CNT_W(CNT_W)) u_acq (
    .clk(clk), .rst(rst), .run(early_q && !steer_q), .len(acq_len),
    .expire(acq_exp)
  );

  dtmf_steer_timer #(.CNT_W(CNT_W)) u_rel (
    .clk(clk), .rst(rst), .run(!early_q && steer_q), .len(rel_len),
    .expire(rel_exp)
  );

  always_ff @(posedge clk) begin
    if (rst)          steer_q <= 1'b0;
    else if (acq_exp) steer_q <= 1'b1;
    else if (rel_exp) steer_q <= 1'b0;
  end

  dtmf_steer_latch u_latch (
    .clk(clk), .rst(rst), .load(acq_exp), .code_in(code_q),
    .digit_q(digit_q), .new_q(new_o)
  );

  assign early_o = early_q;
  assign steer_o = steer_q;
  assign guard_o = early_q ^ steer_q;
  assign digit_o = digit_q;

  // R7
  rise_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(steer_o) |-> new_o);
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    new_o |=> !new_o);
  // R7
  digit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !new_o |-> $stable(digit_o));
  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(steer_o) |-> $past(early_o));
  // R5
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(steer_o) |-> $past(!early_o));
endmodule

// File: tb/dtmf_steer_tb.sv
module dtmf_steer_tb_top;
  localparam int CW = 4;
  logic clk = 1'b0, rst = 1'b1, pair_vld = 1'b0;
  logic [3:0] pair_code = '0;
  logic [CW-1:0] acq_len = '0, rel_len = '0;
  logic early_o, steer_o, guard_o, new_o;
  logic [3:0] digit_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dtmf_steer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .pair_vld(pair_vld), .pair_code(pair_code),
    .acq_len(acq_len), .rel_len(rel_len), .early_o(early_o),
    .steer_o(steer_o), .guard_o(guard_o), .digit_o(digit_o), .new_o(new_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_guard();
    chk("R8 guard", guard_o, int'(early_o != steer_o));
  endtask

  task automatic run_combo(input int L, input int R, input logic [3:0] c);
    int effl = (L == 0) ? 1 : L;
    int effr = (R == 0) ? 1 : R;
    logic [3:0] prev = digit_o;
    acq_len = CW'(L);
    rel_len = CW'(R);
    // R4: onset shorter than the guard
    if (effl >= 2) begin
      pair_code = c;
      pair_vld = 1'b1;
      repeat (effl - 1) @(negedge clk);
      pair_vld = 1'b0;
      repeat (3) begin
        @(negedge clk);
        chk("R4 steer", steer_o, 0);
        chk("R4 digit", digit_o, prev);
        chk("R4 new", new_o, 0);
      end
    end
    // R3 / R2: full acquisition
    pair_code = c;
    pair_vld = 1'b1;
    @(negedge clk);
    chk("R2 early rise", early_o, 1);
    chk_guard();
    for (int i = 1; i < effl; i++) begin
      @(negedge clk);
      chk("R3 steer early", steer_o, 0);
      chk("R9 no strobe", new_o, 0);
    end
    @(negedge clk);
    chk("R3 steer rise", steer_o, 1);
    chk("R3 digit", digit_o, c);
    chk("R7 strobe", new_o, 1);
    chk_guard();
    pair_code = ~c;
    repeat (3) begin
      @(negedge clk);
      chk("R7 strobe once", new_o, 0);
      chk("R7 code ignored", digit_o, c);
    end
    // R6: short gap while steered
    if (effr >= 2) begin
      pair_vld = 1'b0;
      repeat (effr - 1) @(negedge clk);
      pair_vld = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk("R6 steer held", steer_o, 1);
        chk("R6 no strobe", new_o, 0);
        chk("R6 digit", digit_o, c);
      end
    end
    // R5: release
    pair_vld = 1'b0;
    @(negedge clk);
    chk("R2 early fall", early_o, 0);
    chk_guard();
    for (int i = 1; i < effr; i++) begin
      @(negedge clk);
      chk("R5 steer held", steer_o, 1);
    end
    @(negedge clk);
    chk("R5 steer fall", steer_o, 0);
    chk("R5 digit kept", digit_o, c);
    chk_guard();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 early", early_o, 0);
    chk("R1 steer", steer_o, 0);
    chk("R1 guard", guard_o, 0);
    chk("R1 new", new_o, 0);
    chk("R1 digit", digit_o, 0);
    for (int l = 0; l <= 4; l++)
      for (int r = 0; r <= 4; r++)
        run_combo(l, r, 4'((l * 5 + r * 3 + 1) & 15));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule